// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

This block is a parameterised, purely combinational datapath that applies one of fourteen word operations to two operands. Every bit position is the same slice, repeated across the word. Each slice holds a full adder whose second operand comes from a small selector, a two-input logic cell, and a four-way output selector. That output selector chooses between the adder sum, the logic result and the two neighbouring bits of operand A.

A four-bit select field and a carry input together pick the operation. The upper select pair names the group: arithmetic, logic, shift right or shift left. The lower pair names the variant inside the arithmetic and logic groups. In the arithmetic group the carry input adds one more to the sum. Alongside the word result, the block reports the carry out of the most significant bit and a signed overflow flag. Both flags read zero outside the arithmetic group.

The result settles in the same cycle as the operands. Any registers that source or capture the operands belong to the surrounding datapath.

Top module: `alsu_top`

## Requirements
- R1: With sel_i = 4'b0000 the result is (a_i + b_i + cin_i) modulo 2^W.
- R2: With sel_i = 4'b0001 the result is (a_i + ~b_i + cin_i) modulo 2^W, so cin_i = 1 gives a_i - b_i and cin_i = 0 gives a_i - b_i - 1.
- R3: With sel_i = 4'b0010 the result is a_i + cin_i modulo 2^W, which is a transfer when cin_i = 0 and an increment when cin_i = 1.
- R4: With sel_i = 4'b0011 the result is (a_i + all-ones + cin_i) modulo 2^W, which is a decrement when cin_i = 0 and a transfer when cin_i = 1.
- R5: In the arithmetic group (sel_i[3:2] = 2'b00), cout_o equals bit W of the (W+1)-bit sum a_i + Y + cin_i, where Y is the second operand named in R1 to R4.
- R6: In the arithmetic group, ovf_o is 1 exactly when a_i and Y have the same most significant bit and the result's most significant bit differs from it. This equals the XOR of the carries into and out of the top bit.
- R7: With sel_i[3:2] = 2'b01 the result is a_i AND b_i for sel_i[1:0] = 00, OR for 01, XOR for 10, and NOT a_i for 11.
- R8: With sel_i[3:2] = 2'b10 the result is a_i shifted right by one: bit i takes a_i[i+1], and the top bit takes 0.
- R9: With sel_i[3:2] = 2'b11 the result is a_i shifted left by one: bit i takes a_i[i-1], and bit 0 takes 0.
- R10: cin_i has no effect on the result in the logic and shift groups, and sel_i[1:0] has no effect in the shift groups.
- R11: cout_o and ovf_o are both 0 whenever sel_i[3:2] is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand, and the source of both shifts |
| b_i | input | W | Second operand |
| sel_i | input | 4 | Operation select: [3:2] group, [1:0] variant |
| cin_i | input | 1 | Carry input, used by the arithmetic group only |
| f_o | output | W | Operation result |
| cout_o | output | 1 | Carry out of the top bit, arithmetic only |
| ovf_o | output | 1 | Signed overflow, arithmetic only |

## Verification
The block has no register between inputs and outputs, so the result and both flags are due in the same cycle that the operands and select are applied. The bench changes every input on the falling clock edge. It reads f_o, cout_o and ovf_o one nanosecond later, after the ripple carry has settled and well before the next rising edge. No check looks back at an earlier vector, so every comparison pairs one applied stimulus with the outputs it produced.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'b00,
    GRP_LOGIC = 2'b01,
    GRP_SHR   = 2'b10,
    GRP_SHL   = 2'b11
  } alsu_grp_e;

  typedef enum logic [1:0] {
    YSEL_B    = 2'b00,
    YSEL_NB   = 2'b01,
    YSEL_ZERO = 2'b10,
    YSEL_ONES = 2'b11
  } alsu_ysel_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'b00,
    LOP_OR  = 2'b01,
    LOP_XOR = 2'b10,
    LOP_NOT = 2'b11
  } alsu_lop_e;

endpackage

// File: rtl/alsu_arith_cell.sv
module alsu_arith_cell
  import alsu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic [1:0] ysel_i,
  input  logic       c_i,
  output logic       sum_o,
  output logic       c_o
);

  logic y;

  always_comb begin
    unique case (alsu_ysel_e'(ysel_i))
      YSEL_B:    y = b_i;
      YSEL_NB:   y = ~b_i;
      YSEL_ZERO: y = 1'b0;
      default:   y = 1'b1;
    endcase
  end

  assign sum_o = a_i ^ y ^ c_i;
  assign c_o   = (a_i & y) | (c_i & (a_i ^ y));

endmodule

// File: rtl/alsu_logic_cell.sv
module alsu_logic_cell
  import alsu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic [1:0] lop_i,
  output logic       e_o
);

  always_comb begin
    unique case (alsu_lop_e'(lop_i))
      LOP_AND: e_o = a_i & b_i;
      LOP_OR:  e_o = a_i | b_i;
      LOP_XOR: e_o = a_i ^ b_i;
      default: e_o = ~a_i;
    endcase
  end

endmodule

// File: rtl/alsu_bit_stage.sv
module alsu_bit_stage
  import alsu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic       up_i,
  input  logic       dn_i,
  input  logic [3:0] sel_i,
  input  logic       c_i,
  output logic       c_o,
  output logic       f_o
);

  logic sum;
  logic lres;

  alsu_arith_cell u_arith (
    .a_i    (a_i),
    .b_i    (b_i),
    .ysel_i (sel_i[1:0]),
    .c_i    (c_i),
    .sum_o  (sum),
    .c_o    (c_o)
  );

  alsu_logic_cell u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .lop_i (sel_i[1:0]),
    .e_o   (lres)
  );

  always_comb begin
    unique case (alsu_grp_e'(sel_i[3:2]))
      GRP_ARITH: f_o = sum;
      GRP_LOGIC: f_o = lres;
      GRP_SHR:   f_o = up_i;
      default:   f_o = dn_i;
    endcase
  end

endmodule

// File: rtl/alsu_flags.sv
module alsu_flags
  import alsu_pkg::*;
(
  input  logic [1:0] grp_i,
  input  logic       c_msb_in_i,
  input  logic       c_msb_out_i,
  output logic       cout_o,
  output logic       ovf_o
);

  logic is_arith;

  assign is_arith = (grp_i == GRP_ARITH);
  assign cout_o   = is_arith & c_msb_out_i;
  assign ovf_o    = is_arith & (c_msb_in_i ^ c_msb_out_i);

endmodule

// File: rtl/alsu_top.sv
module alsu_top
  import alsu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   sel_i,
  input  logic         cin_i,
  output logic [W-1:0] f_o,
  output logic         cout_o,
  output logic         ovf_o
);

  localparam int PADW = W + 2;
  localparam int MSB  = W - 1;

  logic [W:0]      carry;
  logic [PADW-1:0] a_pad;

  assign carry[0] = cin_i;
  assign a_pad    = {1'b0, a_i, 1'b0};

  for (genvar g = 0; g < W; g++) begin : g_stage
    alsu_bit_stage u_stage (
      .a_i   (a_i[g]),
      .b_i   (b_i[g]),
      .up_i  (a_pad[g+2]),
      .dn_i  (a_pad[g]),
      .sel_i (sel_i),
      .c_i   (carry[g]),
      .c_o   (carry[g+1]),
      .f_o   (f_o[g])
    );
  end

  alsu_flags u_flags (
    .grp_i       (sel_i[3:2]),
    .c_msb_in_i  (carry[W-1]),
    .c_msb_out_i (carry[W]),
    .cout_o      (cout_o),
    .ovf_o       (ovf_o)
  );

  always_comb begin
    // R3
    xfer_chk: assert (!(sel_i == 4'b0010 && !cin_i) || f_o == a_i);
    // R7
    not_chk: assert (sel_i != 4'b0111 || f_o == ~a_i);
    // R8
    shr_chk: assert (sel_i[3:2] != 2'b10 || f_o == (a_i >> 1));
    // R9
    shl_chk: assert (sel_i[3:2] != 2'b11 || f_o == (a_i << 1));
    // R11
    no_flag_chk: assert (sel_i[3:2] == 2'b00 || (!cout_o && !ovf_o));
    // R6
    add_ovf_chk: assert (!(sel_i == 4'b0000 && ovf_o) ||
                         (a_i[MSB] == b_i[MSB] && f_o[MSB] != a_i[MSB]));
  end

endmodule

// File: tb/alsu_top_bench.sv
module alsu_top_bench;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic [3:0]   sel;
  logic         cin;
  logic [W-1:0] f;
  logic         cout;
  logic         ovf;

  int checks;
  int errors;
  bit done;

  alsu_top #(.W(W)) u_alsu_top (
    .a_i    (a),
    .b_i    (b),
    .sel_i  (sel),
    .cin_i  (cin),
    .f_o    (f),
    .cout_o (cout),
    .ovf_o  (ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [W-1:0] y_of(logic [W-1:0] bb, logic [1:0] v);
    case (v)
      2'b00:   return bb;
      2'b01:   return ~bb;
      2'b10:   return '0;
      default: return '1;
    endcase
  endfunction

  function automatic logic [W+1:0] model(logic [W-1:0] aa, logic [W-1:0] bb,
                                         logic [3:0] s, logic c);
    logic [W:0]   sum;
    logic [W-1:0] y;
    logic [W-1:0] r;
    logic         v;
    v = 1'b0;
    case (s[3:2])
      2'b00: begin
        y   = y_of(bb, s[1:0]);
        sum = {1'b0, aa} + {1'b0, y} + {{W{1'b0}}, c};
        v   = (aa[W-1] == y[W-1]) && (sum[W-1] != aa[W-1]);
        return {sum[W], v, sum[W-1:0]};
      end
      2'b01: begin
        case (s[1:0])
          2'b00:   r = aa & bb;
          2'b01:   r = aa | bb;
          2'b10:   r = aa ^ bb;
          default: r = ~aa;
        endcase
      end
      2'b10:   r = aa >> 1;
      default: r = aa << 1;
    endcase
    return {2'b00, r};
  endfunction

  function automatic string f_tag(logic [3:0] s);
    case (s[3:2])
      2'b00: begin
        case (s[1:0])
          2'b00:   return "R1";
          2'b01:   return "R2";
          2'b10:   return "R3";
          default: return "R4";
        endcase
      end
      2'b01:   return "R7";
      2'b10:   return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h sel=%b cin=%b)",
               tag, act, exp, a, b, sel, cin);
    end
  endtask

  task automatic drive(logic [W-1:0] aa, logic [W-1:0] bb, logic [3:0] s, logic c);
    @(negedge clk);
    a = aa; b = bb; sel = s; cin = c;
    #1;
  endtask

  task automatic run_vec(logic [W-1:0] aa, logic [W-1:0] bb, logic [3:0] s, logic c);
    logic [W+1:0] e;
    drive(aa, bb, s, c);
    e = model(aa, bb, s, c);
    check(f_tag(s), f, e[W-1:0]);
    check((s[3:2] == 2'b00) ? "R5" : "R11", {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, e[W+1]});
    check((s[3:2] == 2'b00) ? "R6" : "R11", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, e[W]});
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    a = '0; b = '0; sel = '0; cin = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    void'($urandom(32'd4711));

    // Idle state after reset: zero operands, add, no carry in (R1)
    @(negedge clk); #1;
    check("R1", f, '0);
    check("R11", {{(W-1){1'b0}}, cout | ovf}, '0);

    // Directed corners with literal expectations
    drive(8'h7F, 8'h01, 4'b0000, 1'b0);
    check("R6", {{(W-1){1'b0}}, ovf}, 8'h01);
    check("R1", f, 8'h80);
    drive(8'hFF, 8'h01, 4'b0000, 1'b0);
    check("R5", {{(W-1){1'b0}}, cout}, 8'h01);
    check("R6", {{(W-1){1'b0}}, ovf}, 8'h00);
    drive(8'h80, 8'h01, 4'b0001, 1'b1);
    check("R2", f, 8'h7F);
    check("R6", {{(W-1){1'b0}}, ovf}, 8'h01);
    drive(8'h00, 8'h55, 4'b0011, 1'b0);
    check("R4", f, 8'hFF);
    check("R5", {{(W-1){1'b0}}, cout}, 8'h00);
    drive(8'hFF, 8'h00, 4'b0010, 1'b1);
    check("R3", f, 8'h00);
    check("R5", {{(W-1){1'b0}}, cout}, 8'h01);
    drive(8'h81, 8'h00, 4'b1000, 1'b1);
    check("R8", f, 8'h40);
    drive(8'h81, 8'h00, 4'b1100, 1'b1);
    check("R9", f, 8'h02);
    drive(8'hFF, 8'hFF, 4'b1111, 1'b1);
    check("R11", {{(W-1){1'b0}}, cout | ovf}, '0);

    // R10: vary carry in and variant bits where they must not matter
    for (int k = 0; k < 64; k++) begin
      logic [W-1:0] ra;
      logic [W-1:0] rb;
      logic [1:0]   grp;
      logic [W+1:0] e;
      ra  = W'($urandom);
      rb  = W'($urandom);
      grp = 2'(1 + (k % 3));
      for (int v = 0; v < 4; v++) begin
        for (int c = 0; c < 2; c++) begin
          logic [3:0] s;
          s = {grp, (grp == 2'b01) ? 2'(k >> 2) : 2'(v)};
          e = model(ra, rb, {grp, (grp == 2'b01) ? s[1:0] : 2'b00}, 1'b0);
          drive(ra, rb, s, c[0]);
          check("R10", f, e[W-1:0]);
        end
      end
    end

    // Constrained random across all fourteen operations
    for (int k = 0; k < 3000; k++) begin
      run_vec(W'($urandom), W'($urandom), 4'($urandom), 1'($urandom));
    end

    // Operand extremes for every select and carry
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 2; c++) begin
        run_vec('1, '1, 4'(s), c[0]);
        run_vec({1'b1, {(W-1){1'b0}}}, {1'b0, {(W-1){1'b1}}}, 4'(s), c[0]);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule